// File: doc/BRIEF.md
# Layered Keyed Bus Scrambler

This block hides the value of a 16-bit word on a bus or memory port behind a keyed, reversible transform that finishes within one clock cycle. The network has four layers. Each layer holds four 4-bit cells. In every cell, two bits pass through unchanged and act as a selector. The selector picks three key bits, and those three bits decide how the other two bits are swapped and inverted. A fixed wiring pattern joins the layers. It turns each layer's selector bits into the next layer's transformed bits, and it feeds every cell from four different cells of the layer before.

A mode input picks the direction of each word. In scramble mode the word runs through the forward network. In descramble mode it runs through the exact inverse network, which visits the layers in reverse order. The result is registered. The 192-bit key is written as six 32-bit words before each protected run. It only replaces the key in use when the sixth word arrives, so a key load in progress never disturbs traffic.

Top module: `bus_scrambler`

## Requirements
- R1: After synchronous reset, `dout` is zero, the active key is all zeros and the next key write goes to word 0.
- R2: `dout` is a register. The word and mode sampled at clock edge n appear on `dout` right after edge n, and a new word can be accepted at every edge.
- R3: Key writes fill six 32-bit words in order. Write number i (counted from 0) supplies key bits [32i+31:32i]. The sixth write replaces the active key with the full new value, and the index then returns to word 0.
- R4: Writing the first one to five words of a key has no effect on `dout`. Words keep being processed with the previous complete key.
- R5: If a word is processed in the same cycle as the sixth key write, it uses the old key. Words from the next cycle onwards use the new key.
- R6: Cell function. For layer l and cell c, with bits [4c+3:4c], the cell key is bits [(4l+c)*12+11:(4l+c)*12]. The two high bits are the selector v and pass through unchanged. They pick the group g = cell key [3v+2:3v]. Forward mode: if g[0] is set, the two low bits are swapped, and the result is then XORed with g[2:1]. Inverse mode: the two low bits are XORed with g[2:1], and the result is then swapped if g[0] is set.
- R7: Inter-layer wiring. Output bit 4j+p of the wiring (cell j, bit p in 0..3) takes input bit 4*((j+p) mod 4) + ((p+2) mod 4).
- R8: Scrambling (`mode`=0) applies layer 0, wiring, layer 1, wiring, layer 2, wiring, layer 3, with no wiring after the last layer. With a zero key this reduces to three passes of the R7 wiring.
- R9: Descrambling (`mode`=1) applies inverse cells and the inverse wiring from layer 3 down to layer 0, so descrambling a scrambled word under the same key returns the original word.
- R10: `mode` may change every cycle. Each word is processed in the direction sampled with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 1 | 0 = scramble, 1 = descramble |
| din | input | 16 | Word to process |
| key_wr | input | 1 | Key word write strobe |
| key_wdata | input | 32 | Key word value |
| dout | output | 16 | Registered processed word |

## Verification
The two functions that can fall in the same clock edge are the sixth key write, which commits the key, and the processing of a word. The bench provokes this by driving `din` together with the last key word. It then expects the result to match the model under the previous key, and the following cycle's result of the same word to match the new key. A partial load is also interleaved with traffic, and the bench judges that the output still follows the old key until the sixth word.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int CELL_W     = 4;
  localparam int CELL_KEY_W = 12;
  localparam int GRP_W      = 3;
endpackage

// File: rtl/scr_cell.sv
module scr_cell
  import scr_pkg::*;
#(
  parameter bit INVERSE = 1'b0
) (
  input  logic [CELL_W-1:0]     d,
  input  logic [CELL_KEY_W-1:0] k,
  output logic [CELL_W-1:0]     q
);
  logic [1:0]       sel;
  logic [GRP_W-1:0] grp;
  logic [1:0]       mid;
  logic [1:0]       res;

  assign sel = d[3:2];
  assign grp = k[GRP_W*sel +: GRP_W];

  generate
    if (INVERSE) begin : g_inv
      assign mid = d[1:0] ^ grp[2:1];
      assign res = grp[0] ? {mid[0], mid[1]} : mid;
    end else begin : g_fwd
      assign mid = grp[0] ? {d[0], d[1]} : d[1:0];
      assign res = mid ^ grp[2:1];
    end
  endgenerate

  assign q = {sel, res};
endmodule

// File: rtl/scr_perm.sv
module scr_perm
  import scr_pkg::*;
#(
  parameter int  DATA_W  = 16,
  parameter bit  INVERSE = 1'b0
) (
  input  logic [DATA_W-1:0] a,
  output logic [DATA_W-1:0] o
);
  localparam int CELLS = DATA_W / CELL_W;

  for (genvar j = 0; j < CELLS; j++) begin : g_cell
    for (genvar p = 0; p < CELL_W; p++) begin : g_bit
      localparam int SRC = CELL_W * ((j + p) % CELLS) + ((p + 2) % CELL_W);
      if (INVERSE) begin : g_inv
        assign o[SRC] = a[CELL_W*j + p];
      end else begin : g_fwd
        assign o[CELL_W*j + p] = a[SRC];
      end
    end
  end
endmodule

// File: rtl/scr_keyreg.sv
module scr_keyreg #(
  parameter int KEY_W  = 192,
  parameter int WORD_W = 32,
  parameter int WORDS  = KEY_W / WORD_W,
  parameter int CNT_W  = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  output logic [KEY_W-1:0]  key,
  output logic [CNT_W-1:0]  idx
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  logic [KEY_W-1:0] stage_q;
  logic [KEY_W-1:0] stage_nx;

  always_comb begin
    stage_nx = stage_q;
    stage_nx[idx*WORD_W +: WORD_W] = wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      key     <= '0;
      idx     <= '0;
    end else if (wr) begin
      stage_q <= stage_nx;
      if (idx == LAST) begin
        key <= stage_nx;
        idx <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/bus_scrambler.sv
module bus_scrambler
  import scr_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int LAYERS   = 4,
  parameter int KWORD_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode,
  input  logic [DATA_W-1:0]  din,
  input  logic               key_wr,
  input  logic [KWORD_W-1:0] key_wdata,
  output logic [DATA_W-1:0]  dout
);
  localparam int CELLS = DATA_W / CELL_W;
  localparam int KEY_W = LAYERS * CELLS * CELL_KEY_W;
  localparam int WORDS = KEY_W / KWORD_W;
  localparam int CNT_W = $clog2(WORDS);

  logic [KEY_W-1:0]  key_act;
  logic [CNT_W-1:0]  load_idx;
  logic [DATA_W-1:0] fwd   [0:LAYERS];
  logic [DATA_W-1:0] fcell [0:LAYERS-1];
  logic [DATA_W-1:0] rev   [0:LAYERS];
  logic [DATA_W-1:0] rcell [0:LAYERS-1];
  logic [DATA_W-1:0] result;

  scr_keyreg #(.KEY_W(KEY_W), .WORD_W(KWORD_W), .WORDS(WORDS), .CNT_W(CNT_W)) u_key (
    .clk(clk), .rst(rst), .wr(key_wr), .wdata(key_wdata), .key(key_act), .idx(load_idx)
  );

  assign fwd[0] = din;
  assign rev[0] = din;

  for (genvar l = 0; l < LAYERS; l++) begin : g_fwd
    for (genvar c = 0; c < CELLS; c++) begin : g_c
      scr_cell #(.INVERSE(1'b0)) u_cell (
        .d(fwd[l][CELL_W*c +: CELL_W]),
        .k(key_act[(l*CELLS + c)*CELL_KEY_W +: CELL_KEY_W]),
        .q(fcell[l][CELL_W*c +: CELL_W])
      );
    end
    if (l < LAYERS - 1) begin : g_wire
      scr_perm #(.DATA_W(DATA_W), .INVERSE(1'b0)) u_perm (.a(fcell[l]), .o(fwd[l+1]));
    end else begin : g_last
      assign fwd[l+1] = fcell[l];
    end
  end

  for (genvar i = 0; i < LAYERS; i++) begin : g_rev
    localparam int LI = LAYERS - 1 - i;
    for (genvar c = 0; c < CELLS; c++) begin : g_c
      scr_cell #(.INVERSE(1'b1)) u_cell (
        .d(rev[i][CELL_W*c +: CELL_W]),
        .k(key_act[(LI*CELLS + c)*CELL_KEY_W +: CELL_KEY_W]),
        .q(rcell[i][CELL_W*c +: CELL_W])
      );
    end
    if (LI > 0) begin : g_wire
      scr_perm #(.DATA_W(DATA_W), .INVERSE(1'b1)) u_perm (.a(rcell[i]), .o(rev[i+1]));
    end else begin : g_last
      assign rev[i+1] = rcell[i];
    end
  end

  assign result = mode ? rev[LAYERS] : fwd[LAYERS];

  always_ff @(posedge clk) begin
    if (rst) dout <= '0;
    else     dout <= result;
  end
endmodule

// File: rtl/scr_chk.sv
module scr_chk #(
  parameter int DATA_W = 16,
  parameter int KEY_W  = 192,
  parameter int WORDS  = 6,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              key_wr,
  input logic [CNT_W-1:0]  load_idx,
  input logic [KEY_W-1:0]  key_act,
  input logic [DATA_W-1:0] dout
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORDS - 1);

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dout == '0 && key_act == '0 && load_idx == '0));

  // R4
  key_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(key_wr && load_idx == LAST) |=> $stable(key_act));

  // R3
  idx_step_chk: assert property (@(posedge clk) disable iff (rst)
    (key_wr && load_idx != LAST) |=> (load_idx == $past(load_idx) + 1'b1));

  // R3
  idx_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (key_wr && load_idx == LAST) |=> (load_idx == '0));

  // R3
  idx_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !key_wr |=> $stable(load_idx));

  // R3
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    load_idx <= LAST);
endmodule

bind bus_scrambler scr_chk #(
  .DATA_W(DATA_W), .KEY_W(KEY_W), .WORDS(WORDS), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst(rst), .key_wr(key_wr), .load_idx(load_idx),
  .key_act(key_act), .dout(dout)
);

// File: tb/bus_scrambler_test.sv
`timescale 1ns/1ps
module bus_scrambler_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode = 1'b0;
  logic [15:0] din = '0;
  logic        key_wr = 1'b0;
  logic [31:0] key_wdata = '0;
  logic [15:0] dout;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_scrambler uut (
    .clk(clk), .rst(rst), .mode(mode), .din(din),
    .key_wr(key_wr), .key_wdata(key_wdata), .dout(dout)
  );

  localparam logic [191:0] K1 = {64'h3c5a_9e07_71b2_d4e8, 64'h0f1e_2d3c_4b5a_6978, 64'h8796_a5b4_c3d2_e1f0};
  localparam logic [191:0] K2 = {64'hdead_beef_0123_4567, 64'h89ab_cdef_fedc_ba98, 64'h7654_3210_5a5a_a5a5};
  localparam logic [191:0] K3 = {64'h1357_9bdf_2468_ace0, 64'hffff_0000_f0f0_0f0f, 64'hc3c3_3c3c_9669_6996};

  function automatic logic [15:0] m_perm(input logic [15:0] a, input bit inv);
    logic [15:0] o;
    for (int j = 0; j < 4; j++)
      for (int p = 0; p < 4; p++) begin
        if (inv) o[4*((j+p)%4) + (p+2)%4] = a[4*j+p];
        else     o[4*j+p] = a[4*((j+p)%4) + (p+2)%4];
      end
    return o;
  endfunction

  function automatic logic [3:0] m_cell(input logic [3:0] d, input logic [11:0] k, input bit inv);
    logic [2:0] g;
    logic [1:0] t;
    g = k[3*d[3:2] +: 3];
    if (!inv) begin
      t = g[0] ? {d[0], d[1]} : d[1:0];
      t = t ^ g[2:1];
    end else begin
      t = d[1:0] ^ g[2:1];
      t = g[0] ? {t[0], t[1]} : t;
    end
    return {d[3:2], t};
  endfunction

  function automatic logic [15:0] m_layer(input logic [15:0] x, input logic [191:0] k, input int l, input bit inv);
    logic [15:0] y;
    for (int c = 0; c < 4; c++) y[4*c +: 4] = m_cell(x[4*c +: 4], k[(4*l+c)*12 +: 12], inv);
    return y;
  endfunction

  function automatic logic [15:0] model(input logic [15:0] x, input logic [191:0] k, input bit md);
    logic [15:0] v = x;
    if (!md) begin
      for (int l = 0; l < 4; l++) begin
        v = m_layer(v, k, l, 1'b0);
        if (l < 3) v = m_perm(v, 1'b0);
      end
    end else begin
      for (int l = 3; l >= 0; l--) begin
        v = m_layer(v, k, l, 1'b1);
        if (l > 0) v = m_perm(v, 1'b1);
      end
    end
    return v;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: dout=%h expected %h", req, got, exp);
    end
  endtask

  task automatic run_word(input logic [15:0] x, input bit md, output logic [15:0] y);
    @(negedge clk);
    din = x; mode = md;
    @(posedge clk); #1;
    y = dout;
  endtask

  task automatic write_words(input logic [191:0] k, input int first, input int last);
    for (int i = first; i <= last; i++) begin
      @(negedge clk);
      key_wr = 1'b1; key_wdata = k[32*i +: 32];
    end
    @(negedge clk);
    key_wr = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] y;
    @(posedge clk); #1;
    chk("R1 reset output", dout, 16'h0000);
    @(negedge clk); rst = 1'b0;
    run_word(16'h1234, 1'b0, y);
    chk("R1 zero key after reset", y, model(16'h1234, '0, 1'b0));
  endtask

  task automatic t_zero_key();
    logic [15:0] y;
    logic [15:0] pats [3] = '{16'h0001, 16'h8000, 16'hA5C3};
    for (int i = 0; i < 3; i++) begin
      run_word(pats[i], 1'b0, y);
      chk("R7 R8 zero-key wiring", y, m_perm(m_perm(m_perm(pats[i], 1'b0), 1'b0), 1'b0));
    end
  endtask

  task automatic t_key1();
    logic [15:0] y, z;
    logic [15:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h6C1B, 16'h9E42};
    write_words(K1, 0, 5);
    for (int i = 0; i < 4; i++) begin
      run_word(pats[i], 1'b0, y);
      chk("R3 R6 scramble with loaded key", y, model(pats[i], K1, 1'b0));
      run_word(y, 1'b1, z);
      chk("R9 descramble round trip", z, pats[i]);
    end
  endtask

  task automatic t_partial();
    logic [15:0] y;
    write_words(K2, 0, 2);
    run_word(16'h4D2F, 1'b0, y);
    chk("R4 partial load ignored", y, model(16'h4D2F, K1, 1'b0));
    write_words(K2, 3, 5);
    run_word(16'h4D2F, 1'b0, y);
    chk("R3 key after completed load", y, model(16'h4D2F, K2, 1'b0));
  endtask

  task automatic t_same_cycle();
    write_words(K3, 0, 4);
    @(negedge clk);
    key_wr = 1'b1; key_wdata = K3[160 +: 32];
    din = 16'hB7E1; mode = 1'b0;
    @(posedge clk); #1;
    chk("R5 commit cycle uses old key", dout, model(16'hB7E1, K2, 1'b0));
    @(negedge clk);
    key_wr = 1'b0;
    @(posedge clk); #1;
    chk("R5 next cycle uses new key", dout, model(16'hB7E1, K3, 1'b0));
  endtask

  task automatic t_b2b();
    logic [15:0] xs [6] = '{16'h0F0F, 16'h3141, 16'h2718, 16'hF00D, 16'h1111, 16'hC0DE};
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      din = xs[i]; mode = i[0];
      @(posedge clk); #1;
      chk("R2 R10 back-to-back mode change", dout, model(xs[i], K3, i[0]));
    end
  endtask

  initial begin
    t_reset();
    t_zero_key();
    t_key1();
    t_partial();
    t_same_cycle();
    t_b2b();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule